// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit with Asynchronous Timer

This block collects interrupt events from three timers into one 8-bit flag register and gates them with a matching 8-bit mask register and a global enable. It produces a single interrupt request together with the vector index of the most urgent pending source. The processor clears flags in two ways: it writes ones to the flag register, or it acknowledges a vector.

One of the three timers lives inside the block. It is an 8-bit counter clocked by its own asynchronous timer clock. It has a free-running wrap mode and a phase-correct up/down mode, one compare value, and a compare output pin that is driven in the timer domain. The overflow and compare events of that counter reach the processor domain through toggle synchronizers, so they show up in the flag register a fixed number of processor cycles after the timer edge. Events from the other two timers arrive as single-cycle pulses that are already synchronous to the processor clock.

Software configures the block through a 2-bit register port:
- address 0: flags
- address 1: mask
- address 2: compare value
- address 3: control, where bit 0 runs the counter and bit 1 selects the up/down mode

Software should change the compare value and the control bits only while the counter is stopped.

Top module: `tirq_unit`

## Requirements
- R1: While reset is asserted, every register reads 0, `irq_req` is 0 and `cmp_pin` is 0.
- R2: Bit 1 of the flag register and bit 1 of the mask register always read 0, and writes to that bit have no effect.
- R3: Writing a one to a flag bit (address 0) clears it. Writing a zero to a flag bit leaves it unchanged.
- R4: A pulse on `vec_ack` clears only the flag that belongs to `ack_vec`. The vector-to-bit map is: 0→bit 7 (counter compare), 1→bit 6 (counter overflow), 2→bit 5 (capture), 3→bit 4 (compare A), 4→bit 3 (compare B), 5→bit 2 (timer-1 overflow), 6→bit 0 (timer-0 overflow). `ack_vec` = 7 clears nothing.
- R5: `irq_req` is 1 only when `gie` is 1 and some flag is set whose mask bit is also set.
- R6: When `irq_req` is 1, `irq_vec` gives the lowest vector index (per the R4 map) among the sources that are both flagged and enabled.
- R7: A one-cycle pulse on `sync_evt` sets its flag at the next processor clock edge. The pulse map is: [4]→bit 5, [3]→bit 4, [2]→bit 3, [1]→bit 2, [0]→bit 0.
- R8: When a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends at 1.
- R9: In wrap mode (control = 1) the counter runs from 0 to 255 and wraps. Each wrap sets flag bit 6, so successive overflow flags are 256 timer cycles apart.
- R10: In up/down mode (control = 3) the counter climbs to 255 and then descends to 0. Flag bit 6 is set only when the counter turns around at 0, which gives one overflow every 510 timer cycles.
- R11: A compare match sets flag bit 7 and moves `cmp_pin` on the timer clock edge. In wrap mode the pin toggles on each match. In up/down mode the pin is driven to 0 on a match while counting up and to 1 on a match while counting down.
- R12: A counter event that changes on a timer clock edge becomes visible as a flag (and as `irq_req`) on the third processor clock edge after that timer edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tclk | input | 1 | Asynchronous timer clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 flags, 1 mask, 2 compare, 3 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global interrupt enable |
| sync_evt | input | 5 | Synchronous event pulses from the other timers |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector index of the highest-priority pending source |
| vec_ack | input | 1 | Vector acknowledge strobe |
| ack_vec | input | 3 | Index of the vector being acknowledged |
| cmp_pin | output | 1 | Compare output pin, timer clock domain |

## Verification
The flag logic is exercised with several patterns, each aimed at a specific fault:
- Single synchronous pulses, which separate the flag positions.
- Mixed flag sets, which separate priority ordering from plain masking.
- Cleared and acknowledged subsets, which show that only the addressed bit drops.
- A pulse that lands in the same cycle as a write-one clear, which exposes a clear that wrongly wins.

The counter runs in both modes. Timing the distance between successive overflow flags tells a wrap-at-255 counter apart from a turn-at-zero counter. Timing the distance between opposite pin edges tells toggle behaviour apart from direction-dependent set and clear. Measuring from the pin edge to the request edge pins down the depth of the synchronizer.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int DW   = 8;  // register width
  localparam int NVEC = 7;  // implemented sources
  localparam int VW   = 3;  // vector index width

  typedef enum logic [1:0] {
    A_FLAG = 2'd0,
    A_MASK = 2'd1,
    A_OCR  = 2'd2,
    A_CTL  = 2'd3
  } addr_e;

  // Unimplemented position in flag and mask
  localparam logic [DW-1:0] IMPL = 8'hFD;

  // Vector index to flag bit position (index 0 is most urgent)
  function automatic logic [2:0] vec_bit(input logic [VW-1:0] v);
    case (v)
      3'd0:    vec_bit = 3'd7;
      3'd1:    vec_bit = 3'd6;
      3'd2:    vec_bit = 3'd5;
      3'd3:    vec_bit = 3'd4;
      3'd4:    vec_bit = 3'd3;
      3'd5:    vec_bit = 3'd2;
      3'd6:    vec_bit = 3'd0;
      default: vec_bit = 3'd1;  // unused slot, always zero
    endcase
  endfunction
endpackage

// File: rtl/tirq_rst_sync.sv
module tirq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_n = q2;
endmodule

// File: rtl/tirq_async_timer.sv
module tirq_async_timer #(
  parameter int W = 8
) (
  input  logic         tclk,
  input  logic         trst_n,
  input  logic         run,
  input  logic         pwm,
  input  logic [W-1:0] ocr,
  output logic         cmp_pin,
  output logic         tog_cmp,
  output logic         tog_ovf
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         pin_q, pin_d;
  logic         tc_q, tc_d;
  logic         to_q, to_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    pin_d  = pin_q;
    tc_d   = tc_q;
    to_d   = to_q;
    if (cnt_q == ocr) begin
      tc_d  = ~tc_q;
      pin_d = pwm ? down_q : ~pin_q;
    end
    if (!pwm) begin
      down_d = 1'b0;
      cnt_d  = cnt_q + ONE;
      if (cnt_q == TOP) to_d = ~to_q;
    end else if (!down_q) begin
      if (cnt_q == TOP) begin
        down_d = 1'b1;
        cnt_d  = cnt_q - ONE;
      end else begin
        cnt_d  = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        down_d = 1'b0;
        cnt_d  = cnt_q + ONE;
        to_d   = ~to_q;  // turn-around at bottom
      end else begin
        cnt_d  = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      pin_q  <= 1'b0;
      tc_q   <= 1'b0;
      to_q   <= 1'b0;
    end else if (run) begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      pin_q  <= pin_d;
      tc_q   <= tc_d;
      to_q   <= to_d;
    end
  end

  assign cmp_pin = pin_q;
  assign tog_cmp = tc_q;
  assign tog_ovf = to_q;
endmodule

// File: rtl/tirq_evt_sync.sv
module tirq_evt_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tog,
  output logic [N-1:0] pulse
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= tog[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign pulse[g] = s2 ^ s3;
  end
endmodule

// File: rtl/tirq_regs.sv
module tirq_regs
  import tirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_vec,
  input  logic          vec_ack,
  input  logic [VW-1:0] ack_vec,
  input  logic          gie,
  output logic [DW-1:0] flags,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] ocr,
  output logic          run,
  output logic          pwm,
  output logic [DW-1:0] rdata,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec
);
  logic [DW-1:0] flag_q, flag_d, mask_q, mask_d, ocr_q, ocr_d;
  logic [1:0]    ctl_q, ctl_d;
  logic [DW-1:0] clr, pend;
  logic          any;

  always_comb begin
    clr = '0;
    if (wr && addr == A_FLAG) clr = wdata;
    if (vec_ack && ack_vec < VW'(NVEC)) clr[vec_bit(ack_vec)] = 1'b1;
  end

  always_comb begin
    flag_d = ((flag_q & ~clr) | set_vec) & IMPL;
    mask_d = mask_q;
    ocr_d  = ocr_q;
    ctl_d  = ctl_q;
    if (wr) begin
      case (addr)
        A_MASK:  mask_d = wdata & IMPL;
        A_OCR:   ocr_d  = wdata;
        A_CTL:   ctl_d  = wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      ocr_q  <= '0;
      ctl_q  <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      ocr_q  <= ocr_d;
      ctl_q  <= ctl_d;
    end
  end

  // Priority pick: scan from least urgent so the most urgent overwrites
  assign pend = flag_q & mask_q;
  always_comb begin
    irq_vec = '0;
    any     = 1'b0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (pend[vec_bit(VW'(i))]) begin
        irq_vec = VW'(i);
        any     = 1'b1;
      end
    end
  end

  assign irq_req = gie & any;

  always_comb begin
    case (addr)
      A_FLAG:  rdata = flag_q;
      A_MASK:  rdata = mask_q;
      A_OCR:   rdata = ocr_q;
      default: rdata = {6'b0, ctl_q};
    endcase
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign ocr   = ocr_q;
  assign run   = ctl_q[0];
  assign pwm   = ctl_q[1];
endmodule

// File: rtl/tirq_unit.sv
module tirq_unit
  import tirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          gie,
  input  logic [4:0]    sync_evt,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  input  logic          vec_ack,
  input  logic [VW-1:0] ack_vec,
  output logic          cmp_pin
);
  logic          rst_cpu_n, rst_tmr_n;
  logic [DW-1:0] flags, mask, ocr, set_vec;
  logic          run, pwm, tog_cmp, tog_ovf;
  logic [1:0]    tpulse;

  tirq_rst_sync u_rs_cpu (.clk(clk),  .arst_n(rst_n), .srst_n(rst_cpu_n));
  tirq_rst_sync u_rs_tmr (.clk(tclk), .arst_n(rst_n), .srst_n(rst_tmr_n));

  // Compare value and control are quasi-static while the counter is stopped
  tirq_async_timer #(.W(DW)) u_tmr (
    .tclk(tclk), .trst_n(rst_tmr_n), .run(run), .pwm(pwm), .ocr(ocr),
    .cmp_pin(cmp_pin), .tog_cmp(tog_cmp), .tog_ovf(tog_ovf)
  );

  tirq_evt_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_cpu_n), .tog({tog_cmp, tog_ovf}), .pulse(tpulse)
  );

  assign set_vec = {tpulse[1], tpulse[0], sync_evt[4:1], 1'b0, sync_evt[0]};

  tirq_regs u_regs (
    .clk(clk), .rst_n(rst_cpu_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .set_vec(set_vec), .vec_ack(vec_ack),
    .ack_vec(ack_vec), .gie(gie), .flags(flags), .mask(mask), .ocr(ocr),
    .run(run), .pwm(pwm), .rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );
endmodule

// File: rtl/tirq_unit_chk.sv
module tirq_unit_chk
  import tirq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] flags,
  input logic [DW-1:0] mask,
  input logic [DW-1:0] set_vec,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          vec_ack,
  input logic [VW-1:0] ack_vec,
  input logic          gie,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec
);
  a_r2_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[1] && !mask[1]);

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0) |=> ((flags & $past(wdata) & ~$past(set_vec)) == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && addr == 2'd0) && !vec_ack && set_vec == '0) |=> $stable(flags));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && ack_vec < 3'd7 && !set_vec[vec_bit(ack_vec)])
      |=> !flags[vec_bit($past(ack_vec))]);

  a_r5_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);

  a_r6_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flags[vec_bit(irq_vec)] && mask[vec_bit(irq_vec)]));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

bind tirq_unit tirq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_cpu_n), .flags(flags), .mask(mask),
  .set_vec(set_vec), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
  .vec_ack(vec_ack), .ack_vec(ack_vec), .gie(gie), .irq_req(irq_req),
  .irq_vec(irq_vec)
);

// File: tb/sim_tirq_unit.sv
`timescale 1ns/1ps
module sim_tirq_unit;
  logic       clk, rst_n, tclk, reg_wr, gie, irq_req, vec_ack, cmp_pin;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [4:0] sync_evt;
  logic [2:0] irq_vec, ack_vec;
  int nchk = 0, nfail = 0;

  tirq_unit u0 (.*);

  initial begin clk = 1'b0; forever #4 clk = ~clk; end           // 125 MHz
  initial begin tclk = 1'b0; #1; forever #18 tclk = ~tclk; end   // 36 ns, async phase

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] v);
    @(negedge clk); sync_evt = v;
    @(negedge clk); sync_evt = '0;
  endtask

  task automatic ack(input logic [2:0] v);
    @(negedge clk); vec_ack = 1'b1; ack_vec = v;
    @(negedge clk); vec_ack = 1'b0; ack_vec = '0;
  endtask

  task automatic do_reset;
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    gie = 0; sync_evt = 0; vec_ack = 0; ack_vec = 0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 8'h00, "R1 register reset value", d, 0);
    end
    chk(irq_req == 1'b0, "R1 irq_req in reset", irq_req, 0);
    chk(cmp_pin == 1'b0, "R1 cmp_pin in reset", cmp_pin, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_bit1;
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk(d == 8'hFD, "R2 mask bit1 ignores write", d, 8'hFD);
    pulse(5'h1F);
    rd(2'd0, d);
    chk(d == 8'h3D, "R2 flags bit1 stays zero", d, 8'h3D);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    do_reset();
    pulse(5'h1F);                       // flags 0x3D
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk(d == 8'h3D, "R3 zero write keeps flags", d, 8'h3D);
    wr(2'd0, 8'h24);
    rd(2'd0, d);
    chk(d == 8'h19, "R3 one write clears bits 5,2", d, 8'h19);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    do_reset();
    pulse(5'h1F);
    ack(3'd3);                           // bit 4
    rd(2'd0, d);
    chk(d == 8'h2D, "R4 ack 3 clears bit4 only", d, 8'h2D);
    ack(3'd7);
    rd(2'd0, d);
    chk(d == 8'h2D, "R4 ack 7 clears nothing", d, 8'h2D);
    ack(3'd6);                           // bit 0
    rd(2'd0, d);
    chk(d == 8'h2C, "R4 ack 6 clears bit0", d, 8'h2C);
  endtask

  task automatic t_gate;
    do_reset();
    pulse(5'h01);
    gie = 1'b1; @(negedge clk);
    chk(irq_req == 1'b0, "R5 masked source no request", irq_req, 0);
    wr(2'd1, 8'h01); gie = 1'b0; @(negedge clk);
    chk(irq_req == 1'b0, "R5 gie low no request", irq_req, 0);
    gie = 1'b1; @(negedge clk);
    chk(irq_req == 1'b1, "R5 all three set request", irq_req, 1);
    chk(irq_vec == 3'd6, "R6 timer-0 overflow vector", irq_vec, 6);
  endtask

  task automatic t_prio;
    do_reset();
    gie = 1'b1;
    wr(2'd1, 8'hFF);
    pulse(5'b10011);                     // bits 5, 2, 0
    chk(irq_vec == 3'd2, "R6 capture wins", irq_vec, 2);
    ack(3'd2);
    chk(irq_vec == 3'd5, "R6 timer-1 overflow next", irq_vec, 5);
    wr(2'd1, 8'hF9);                     // disable bit 2
    chk(irq_vec == 3'd6, "R6 masked source skipped", irq_vec, 6);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    do_reset();
    pulse(5'h08);
    rd(2'd0, d);
    chk(d == 8'h10, "R7 sync[3] sets bit4", d, 8'h10);
    pulse(5'h02);
    rd(2'd0, d);
    chk(d == 8'h14, "R7 sync[1] sets bit2", d, 8'h14);
  endtask

  task automatic t_setwins;
    logic [7:0] d;
    do_reset();
    pulse(5'h02);                        // bit 2 set
    @(negedge clk); sync_evt = 5'h02; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h04;
    @(negedge clk); sync_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd0, d);
    chk(d == 8'h04, "R8 set beats clear", d, 8'h04);
  endtask

  task automatic t_normal_ovf;
    time t0, t1;
    int diff;
    do_reset();
    gie = 1'b1;
    wr(2'd1, 8'h60);
    wr(2'd3, 8'h01);
    @(posedge irq_req); t0 = $time;
    pulse(5'h10);                        // capture flag too
    chk(irq_vec == 3'd1, "R6 counter overflow beats capture", irq_vec, 1);
    wr(2'd0, 8'h60);
    @(posedge irq_req); t1 = $time;
    diff = int'(t1 - t0);
    chk(diff >= 9208 && diff <= 9224, "R9 wrap period ns", diff, 9216);
  endtask

  task automatic t_pwm_ovf;
    time t0, t1;
    int diff;
    do_reset();
    gie = 1'b1;
    wr(2'd1, 8'h40);
    wr(2'd3, 8'h03);
    @(posedge irq_req); t0 = $time;
    wr(2'd0, 8'h40);
    @(posedge irq_req); t1 = $time;
    diff = int'(t1 - t0);
    chk(diff >= 18352 && diff <= 18368, "R10 turn-around period ns", diff, 18360);
  endtask

  task automatic t_pwm_pin;
    time t1, t2, t3;
    do_reset();
    wr(2'd2, 8'd100);
    wr(2'd3, 8'h03);
    @(posedge cmp_pin); t1 = $time;      // down-count match
    @(negedge cmp_pin); t2 = $time;      // up-count match
    @(posedge cmp_pin); t3 = $time;
    chk(int'(t2 - t1) == 7200, "R11 down to up match ns", int'(t2 - t1), 7200);
    chk(int'(t3 - t2) == 11160, "R11 up to down match ns", int'(t3 - t2), 11160);
  endtask

  task automatic t_delay;
    time tp, ti, tp2;
    int d;
    do_reset();
    gie = 1'b1;
    wr(2'd2, 8'd50);
    wr(2'd1, 8'h80);
    wr(2'd3, 8'h01);
    @(cmp_pin); tp = $time;
    chk(cmp_pin == 1'b1, "R11 first match toggles pin high", cmp_pin, 1);
    @(posedge irq_req); ti = $time;
    d = int'(ti - tp);
    chk(d > 16 && d <= 24, "R12 sync delay ns", d, 24);
    chk(irq_vec == 3'd0, "R11 compare flag vector", irq_vec, 0);
    wr(2'd0, 8'h80);
    @(cmp_pin); tp2 = $time;
    chk(cmp_pin == 1'b0, "R11 second match toggles pin low", cmp_pin, 0);
    chk(int'(tp2 - tp) == 9216, "R11 wrap-mode match spacing ns", int'(tp2 - tp), 9216);
  endtask

  initial begin
    #3_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    do_reset();
    t_bit1();
    t_w1c();
    t_ack();
    t_gate();
    t_prio();
    t_sync();
    t_setwins();
    t_normal_ovf();
    t_pwm_ovf();
    t_pwm_pin();
    t_delay();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule